// File: doc/BRIEF.md
# Split-Section Binary Ripple Counter

This block is a binary counter made of toggle stages and split into two sections that are not linked inside the block. The low section is one stage that divides its own clock by two. The high section is a ripple chain of `HI_W` stages (three by default) that divides a second clock by eight. Every stage changes state on the falling edge of the clock that drives it. Inside the chain, each stage after the first is clocked by the output of the stage before it. The chain outputs therefore settle one after another within the same time step, and they do not all change at one instant.

Two reset inputs are combined with an AND. When both are high, every stage clears at once, with no clock needed, and the clear overrides both clocks. When only one of them is high, counting goes on as normal.

The integrator decides how the sections are used. The low output can be wired outside the block to the high clock input, which forms a single 4-bit chain that divides by 2, 4, 8 and 16. The high section can also be used alone as a 3-bit counter. In that case the low stage serves as a free divide-by-two, and it is cleared by the same reset.

Top module: `split_ripple_counter`

## Requirements
- R1: When `rst_a` and `rst_b` are both 1, `q_lo` and `q_hi` go to 0 at once, with no clock edge needed.
- R2: When only one of `rst_a` and `rst_b` is 1, nothing is cleared, and both sections keep their values and go on counting.
- R3: `q_lo` inverts on each 1-to-0 transition of `cp_lo_n`, and it does not change on a 0-to-1 transition.
- R4: `q_hi` is an unsigned count with bit 0 as its LSB. It goes up by one on each 1-to-0 transition of `cp_hi_n` and wraps from 7 to 0.
- R5: Edges on `cp_lo_n` do not change `q_hi`, and edges on `cp_hi_n` do not change `q_lo`.
- R6: While the clear is active, falling edges on either clock leave all outputs at 0.
- R7: With `q_lo` wired outside the block to `cp_hi_n`, the value `{q_hi, q_lo}` counts up by one on each falling edge of `cp_lo_n`, runs from 0 to 15, and wraps to 0 on the sixteenth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cp_lo_n | input | 1 | Clock for the divide-by-two stage, active on its falling edge |
| cp_hi_n | input | 1 | Clock for the ripple chain, active on its falling edge |
| rst_a | input | 1 | First reset input; the clear happens only when this and `rst_b` are both high |
| rst_b | input | 1 | Second reset input; the clear happens only when this and `rst_a` are both high |
| q_lo | output | 1 | Output of the divide-by-two stage |
| q_hi | output | HI_W | Count of the ripple chain, LSB first |

## Verification
The bench builds the block with `HI_W` = 3. With that width the chain wraps after eight falling edges, and the externally linked 4-bit count wraps after sixteen, so random pulse runs cross both wrap points many times. Linked mode is formed in the bench by a continuous assignment from `q_lo` to `cp_hi_n`, so the whole ripple from the first stage to the last takes place inside one time step before the sample point. Directed cases apply the clear in the middle of a count with both clocks idle, apply each reset input on its own, and apply clock edges while the clear is held.

// File: rtl/split_ripple_pkg.sv
package split_ripple_pkg;

    // State of one toggle stage: the output bit and a flag that records
    // that at least one clocked update has happened since the last clear.
    typedef struct packed {
        logic q;
        logic armed;
    } tstage_t;

endpackage

// File: rtl/ripple_tstage.sv
module ripple_tstage
    import split_ripple_pkg::*;
(
    input  logic clk_n,
    input  logic clr,
    output logic q
);

    tstage_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.q     = ~st_q.q;
        st_d.armed = 1'b1;
    end

    always_ff @(negedge clk_n or posedge clr) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q = st_q.q;

    AST_TOGGLE_EACH_FALL: assert property (@(negedge clk_n) disable iff (clr)
        st_q.armed |-> (q != $past(q))); // R3

    always @(negedge clk_n) begin
        if (clr) begin
            AST_CLEAR_BEATS_CLOCK: assert (q == 1'b0); // R6
        end
    end

endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int WIDTH = 3
) (
    input  logic             clk_n,
    input  logic             clr,
    output logic [WIDTH-1:0] cnt
);

    logic [WIDTH-1:0] stage_clk;
    logic             armed_d, armed_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stage_clk[i] = clk_n;
        end else begin : g_next
            assign stage_clk[i] = cnt[i-1];
        end
        ripple_tstage u_stage (
            .clk_n (stage_clk[i]),
            .clr   (clr),
            .q     (cnt[i])
        );
    end

    always_comb begin
        armed_d = 1'b1;
    end

    always_ff @(negedge clk_n or posedge clr) begin
        if (clr) armed_q <= 1'b0;
        else     armed_q <= armed_d;
    end

    AST_CHAIN_STEP: assert property (@(negedge clk_n) disable iff (clr)
        armed_q |-> (cnt == $past(cnt) + WIDTH'(1))); // R4

endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter #(
    parameter int HI_W = 3
) (
    input  logic            cp_lo_n,
    input  logic            cp_hi_n,
    input  logic            rst_a,
    input  logic            rst_b,
    output logic            q_lo,
    output logic [HI_W-1:0] q_hi
);

    logic clr;

    assign clr = rst_a & rst_b;

    ripple_tstage u_lo (
        .clk_n (cp_lo_n),
        .clr   (clr),
        .q     (q_lo)
    );

    ripple_chain #(.WIDTH(HI_W)) u_hi (
        .clk_n (cp_hi_n),
        .clr   (clr),
        .cnt   (q_hi)
    );

    always @(negedge cp_hi_n) begin
        if (clr) begin
            AST_HI_HELD_CLEAR: assert (q_hi == '0); // R6
        end
    end

endmodule

// File: tb/sim_split_ripple_counter.sv
module sim_split_ripple_counter;

    localparam int HI_W = 3;
    localparam int HI_MOD = 1 << HI_W;

    logic clk = 1'b0;
    logic cp_lo_n = 1'b1;
    logic hi_drv = 1'b1;
    logic link = 1'b0;
    logic rst_a = 1'b1;
    logic rst_b = 1'b1;
    logic cp_hi_n;
    logic q_lo;
    logic [HI_W-1:0] q_hi;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int m_lo = 0;
    int m_hi = 0;

    always #2.5 clk = ~clk;

    assign cp_hi_n = link ? q_lo : hi_drv;

    split_ripple_counter #(.HI_W(HI_W)) u0 (
        .cp_lo_n (cp_lo_n),
        .cp_hi_n (cp_hi_n),
        .rst_a   (rst_a),
        .rst_b   (rst_b),
        .q_lo    (q_lo),
        .q_hi    (q_hi)
    );

    function automatic int next_lo(input int v);
        return (v + 1) % 2;
    endfunction

    function automatic int next_hi(input int v);
        return (v + 1) % HI_MOD;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_both(input string req);
        check({req, " lo"}, int'(q_lo), m_lo);
        check({req, " hi"}, int'(q_hi), m_hi);
    endtask

    task automatic pulse(input logic do_lo, input logic do_hi);
        @(posedge clk);
        if (do_lo) cp_lo_n = 1'b0;
        if (do_hi) hi_drv = 1'b0;
        @(posedge clk);
        cp_lo_n = 1'b1;
        hi_drv = 1'b1;
        if (do_lo && !link) m_lo = next_lo(m_lo);
        if (do_hi && !link) m_hi = next_hi(m_hi);
        @(negedge clk);
    endtask

    task automatic full_clear();
        @(negedge clk);
        rst_a = 1'b1;
        rst_b = 1'b1;
        @(negedge clk);
        rst_a = 1'b0;
        rst_b = 1'b0;
        m_lo = 0;
        m_hi = 0;
        @(negedge clk);
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7531));
        repeat (2) @(negedge clk);
        check_both("R1 reset state");
        rst_a = 1'b0;
        rst_b = 1'b0;
        @(negedge clk);

        // R3: falling edge toggles, rising edge does not
        @(posedge clk);
        cp_lo_n = 1'b0;
        @(negedge clk);
        check("R3 after fall", int'(q_lo), 1);
        @(posedge clk);
        cp_lo_n = 1'b1;
        @(negedge clk);
        check("R3 after rise", int'(q_lo), 1);
        m_lo = 1;

        // R4: chain wraps after HI_MOD edges; R5 lo unchanged
        for (int i = 0; i < HI_MOD; i++) begin
            pulse(1'b0, 1'b1);
            check_both("R4 R5 chain step");
        end
        check("R4 wrap", int'(q_hi), 0);

        // R1: mid-count clear with both clocks idle
        pulse(1'b1, 1'b1);
        pulse(1'b0, 1'b1);
        #1;
        rst_a = 1'b1;
        #1;
        check("R2 rst_a alone lo", int'(q_lo), m_lo);
        check("R2 rst_a alone hi", int'(q_hi), m_hi);
        rst_b = 1'b1;
        #0.5;
        check("R1 async clear lo", int'(q_lo), 0);
        check("R1 async clear hi", int'(q_hi), 0);
        m_lo = 0;
        m_hi = 0;

        // R6: clock edges while clear held
        @(posedge clk);
        cp_lo_n = 1'b0;
        hi_drv = 1'b0;
        @(posedge clk);
        cp_lo_n = 1'b1;
        hi_drv = 1'b1;
        @(negedge clk);
        check_both("R6 clocks under clear");
        rst_a = 1'b0;
        rst_b = 1'b0;
        @(negedge clk);

        // R2: rst_b alone while counting
        rst_b = 1'b1;
        pulse(1'b1, 1'b1);
        check_both("R2 rst_b alone counting");
        rst_b = 1'b0;

        // Random mix of section pulses and single reset inputs
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r < 3) begin
                pulse(1'b1, 1'b0);
                check_both("R3 R5 random lo");
            end else if (r < 6) begin
                pulse(1'b0, 1'b1);
                check_both("R4 R5 random hi");
            end else if (r == 6) begin
                pulse(1'b1, 1'b1);
                check_both("R3 R4 random both");
            end else begin
                if ($urandom % 2 == 0) rst_a = 1'b1;
                else rst_b = 1'b1;
                pulse(1'b1, 1'b0);
                check_both("R2 random single reset");
                rst_a = 1'b0;
                rst_b = 1'b0;
            end
        end

        // R7: linked 4-bit chain, set up under clear
        rst_a = 1'b1;
        rst_b = 1'b1;
        @(negedge clk);
        link = 1'b1;
        @(negedge clk);
        rst_a = 1'b0;
        rst_b = 1'b0;
        @(negedge clk);
        check("R7 linked start", int'({q_hi, q_lo}), 0);
        for (int i = 1; i <= 40; i++) begin
            pulse(1'b1, 1'b0);
            check("R7 linked count", int'({q_hi, q_lo}), i % (2 * HI_MOD));
        end

        // R1 mid-count in linked mode
        #1;
        rst_a = 1'b1;
        rst_b = 1'b1;
        #1;
        check("R1 linked clear", int'({q_hi, q_lo}), 0);
        rst_a = 1'b0;
        rst_b = 1'b0;
        @(negedge clk);
        for (int i = 1; i <= 16; i++) begin
            pulse(1'b1, 1'b0);
        end
        check("R7 wrap at sixteenth edge", int'({q_hi, q_lo}), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule